// File: doc/BRIEF.md
# PLL Bring-Up Sequencer

This block is a hardware state machine that acts as a simple register-bus master and takes a PLL controller from reset to locked operation without software help. A single start pulse latches a configuration: the feedback multiplier, an optional pre-divider, an optional post-divider and up to five optional output dividers, each with its own valid flag. The sequencer then issues a fixed series of single-word reads and writes on a request/acknowledge port. It waits a set number of cycles where the PLL needs time to settle, polls a status bit while new divider ratios are applied, and raises `done` for one cycle at the end. It runs on the PLL reference clock, so every wait is counted in reference-clock cycles.

The control register is read once at the start into a shadow copy. Each later control step changes one bit of the shadow and writes the whole word out, with no re-read.

States, in order: `S_IDLE` goes to `S_RD_CTRL` on start. The chain then runs `S_CLR_CKMODE` → `S_CLR_ENSRC` → `S_CLR_PLLEN` → `S_WAIT_BYP` (timer) → `S_SET_RST` → `S_SET_DIS` → `S_CLR_PWDN` → `S_CLR_DIS` → `S_WR_MULT`. From there it goes to `S_WR_DIV`, repeated once per configured divider, then `S_GO_CMD` → `S_POLL_STAT` (repeated while busy), but only if an output divider was written. Then `S_CLR_RST` → `S_WAIT_LOCK` (timer) → `S_SET_PLLEN` → `S_DONE` → `S_IDLE`. Each bus state advances on the cycle in which `bus_req` and `bus_ack` are both high. Each wait state advances when its timer reaches zero.

Top module: `pll_bringup_seq`

## Requirements
- R1: After reset, `busy`, `done` and `bus_req` are low. A start pulse while idle begins the sequence with a read of the control register at base+0x100.
- R2: The first three bus writes go to the control register. They clear bit 8, then bit 5, then bit 0 of the value read in R1. Each write carries the full shadow word with all earlier changes applied.
- R3: After the write that clears bit 0, no new bus request starts for at least `BYP_CYC` cycles.
- R4: The next four control writes, in order, set bit 3, set bit 4, clear bit 1 and clear bit 4.
- R5: The multiplier register at base+0x110 then receives `(cfg_mult - 1) & 0xFF`.
- R6: The dividers are written in this order: pre (base+0x114), post (base+0x128), then output dividers 1..5 (base+0x118, +0x11C, +0x120, +0x160, +0x164). Output divider k occupies `cfg_odiv[(k-1)*DIV_W +: DIV_W]` and its valid flag is `cfg_odiv_vld[k-1]`. A divider is written only when its valid flag is set, and the value written is `0x8000 | (ratio - 1)`.
- R7: If at least one output divider was written, the sequencer writes 0x1 to base+0x138. It then reads base+0x13C until a read returns bit 0 = 0. With no output divider configured, neither address is accessed, even if pre or post dividers were written.
- R8: The sequencer then writes the control word with bit 3 cleared. No new request starts for at least `LOCK_CYC` cycles, and then a final control write sets bit 0.
- R9: `done` is high for exactly the one cycle after the final write is acknowledged. `busy` is high from the cycle after the accepted start through that cycle.
- R10: A start pulse while busy is ignored, and configuration inputs are sampled only when a start is accepted.
- R11: While `bus_req` is high and not acknowledged, `bus_req`, `bus_we`, `bus_addr` and `bus_wdata` stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Start pulse, accepted only when idle |
| base_addr | input | ADDR_W | Controller base address |
| cfg_mult | input | MULT_W | Multiplier ratio |
| cfg_prediv | input | DIV_W | Pre-divider ratio |
| cfg_prediv_vld | input | 1 | Pre-divider is configured |
| cfg_postdiv | input | DIV_W | Post-divider ratio |
| cfg_postdiv_vld | input | 1 | Post-divider is configured |
| cfg_odiv | input | 5*DIV_W | Output divider ratios, divider 1 in the low field |
| cfg_odiv_vld | input | 5 | Output divider valid flags |
| bus_req | output | 1 | Bus request |
| bus_we | output | 1 | 1 = write, 0 = read |
| bus_addr | output | ADDR_W | Bus address |
| bus_wdata | output | 32 | Write data |
| bus_rdata | input | 32 | Read data, valid with `bus_ack` |
| bus_ack | input | 1 | Transfer completes when high with `bus_req` |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
The assertions check every cycle that a pending request holds still (R11) and that `done` is a lone pulse followed by idle (R9). They also check that `busy` only rises after a start, that the command address is never touched without an output divider, and that the timer and divider picker stay consistent. The actual order and content of the writes, the minimum wait lengths, the number of status polls and the handling of a start while busy only show up in bench scenarios. Those scenarios vary which dividers are set, the acknowledge latency, the busy-poll length and the multiplier extremes.

// File: rtl/pllseq_pkg.sv
package pllseq_pkg;

    localparam int NUM_ODIV = 5;
    localparam int NUM_SLOT = 2 + NUM_ODIV;

    localparam logic [11:0] OFS_CTRL = 12'h100;
    localparam logic [11:0] OFS_MULT = 12'h110;
    localparam logic [11:0] OFS_CMD  = 12'h138;
    localparam logic [11:0] OFS_STAT = 12'h13C;

    localparam int B_PLLEN  = 0;
    localparam int B_PWRDN  = 1;
    localparam int B_RST    = 3;
    localparam int B_DIS    = 4;
    localparam int B_ENSRC  = 5;
    localparam int B_CKMODE = 8;

    typedef enum logic [4:0] {
        S_IDLE,
        S_RD_CTRL,
        S_CLR_CKMODE,
        S_CLR_ENSRC,
        S_CLR_PLLEN,
        S_WAIT_BYP,
        S_SET_RST,
        S_SET_DIS,
        S_CLR_PWDN,
        S_CLR_DIS,
        S_WR_MULT,
        S_WR_DIV,
        S_GO_CMD,
        S_POLL_STAT,
        S_CLR_RST,
        S_WAIT_LOCK,
        S_SET_PLLEN,
        S_DONE
    } seq_state_t;

    // slot 0 = pre-divider, 1 = post-divider, 2..6 = output dividers 1..5
    function automatic logic [11:0] slot_offset(input int unsigned slot);
        case (slot)
            0:       return 12'h114;
            1:       return 12'h128;
            2:       return 12'h118;
            3:       return 12'h11C;
            4:       return 12'h120;
            5:       return 12'h160;
            default: return 12'h164;
        endcase
    endfunction

endpackage

// File: rtl/pllseq_timer.sv
module pllseq_timer #(
    parameter int CNT_W = 13
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             zero
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n)               cnt_q <= '0;
        else if (load)            cnt_q <= load_val;
        else if (cnt_q != '0)     cnt_q <= cnt_q - 1'b1;
    end

    assign zero = (cnt_q == '0);

    // R3 R8: once expired, the timer stays expired until reloaded
    timer_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        zero && !load |=> zero);

endmodule

// File: rtl/pllseq_slot_pick.sv
module pllseq_slot_pick #(
    parameter int NSLOT  = 7,
    parameter int SLOT_W = $clog2(NSLOT)
) (
    input  logic [NSLOT-1:0]  mask,
    input  logic [SLOT_W:0]   from,
    output logic              found,
    output logic [SLOT_W-1:0] idx
);
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = NSLOT - 1; i >= 0; i--) begin
            if (mask[i] && (i >= int'(from))) begin
                found = 1'b1;
                idx   = SLOT_W'(i);
            end
        end
    end

    // R6: a picked slot is always a configured one at or after the start point
    always_comb begin
        if (found) begin
            pick_valid_chk: assert (mask[idx] && (int'(idx) >= int'(from)));
        end
    end

endmodule

// File: rtl/pll_bringup_seq.sv
module pll_bringup_seq
    import pllseq_pkg::*;
#(
    parameter int ADDR_W   = 32,
    parameter int MULT_W   = 9,
    parameter int DIV_W    = 5,
    parameter int BYP_CYC  = 4,
    parameter int LOCK_CYC = 8000
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     start,
    input  logic [ADDR_W-1:0]        base_addr,
    input  logic [MULT_W-1:0]        cfg_mult,
    input  logic [DIV_W-1:0]         cfg_prediv,
    input  logic                     cfg_prediv_vld,
    input  logic [DIV_W-1:0]         cfg_postdiv,
    input  logic                     cfg_postdiv_vld,
    input  logic [NUM_ODIV*DIV_W-1:0] cfg_odiv,
    input  logic [NUM_ODIV-1:0]      cfg_odiv_vld,
    output logic                     bus_req,
    output logic                     bus_we,
    output logic [ADDR_W-1:0]        bus_addr,
    output logic [31:0]              bus_wdata,
    input  logic [31:0]              bus_rdata,
    input  logic                     bus_ack,
    output logic                     busy,
    output logic                     done
);
    localparam int SLOT_W   = $clog2(NUM_SLOT);
    localparam int WAIT_MAX = (BYP_CYC > LOCK_CYC) ? BYP_CYC : LOCK_CYC;
    localparam int CNT_W    = $clog2(WAIT_MAX + 1);

    seq_state_t        state_q, state_d;
    logic [31:0]       shadow_q;
    logic [ADDR_W-1:0] base_q;
    logic [MULT_W-1:0] mult_q;
    logic [DIV_W-1:0]  ratio_q [NUM_SLOT];
    logic [NUM_SLOT-1:0] vld_q;
    logic [SLOT_W-1:0] slot_q;

    logic              xfer;
    logic              go_armed;
    logic [SLOT_W:0]   pick_from;
    logic              pick_found;
    logic [SLOT_W-1:0] pick_idx;
    logic              tmr_load;
    logic [CNT_W-1:0]  tmr_val;
    logic              tmr_zero;
    logic [MULT_W-1:0] mult_m1;
    logic [DIV_W-1:0]  ratio_m1;

    assign xfer      = bus_req && bus_ack;
    assign go_armed  = |vld_q[NUM_SLOT-1:2];
    assign pick_from = (state_q == S_WR_DIV) ? ({1'b0, slot_q} + 1'b1) : '0;
    assign mult_m1   = mult_q - 1'b1;
    assign ratio_m1  = ratio_q[slot_q] - 1'b1;
    assign tmr_load  = bus_ack && ((state_q == S_CLR_PLLEN) || (state_q == S_CLR_RST));
    assign tmr_val   = (state_q == S_CLR_PLLEN) ? CNT_W'(BYP_CYC - 1) : CNT_W'(LOCK_CYC - 1);

    pllseq_slot_pick #(.NSLOT(NUM_SLOT), .SLOT_W(SLOT_W)) u_pick (
        .mask  (vld_q),
        .from  (pick_from),
        .found (pick_found),
        .idx   (pick_idx)
    );

    pllseq_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .zero     (tmr_zero)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:       if (start) state_d = S_RD_CTRL;
            S_RD_CTRL:    if (xfer) state_d = S_CLR_CKMODE;
            S_CLR_CKMODE: if (xfer) state_d = S_CLR_ENSRC;
            S_CLR_ENSRC:  if (xfer) state_d = S_CLR_PLLEN;
            S_CLR_PLLEN:  if (xfer) state_d = S_WAIT_BYP;
            S_WAIT_BYP:   if (tmr_zero) state_d = S_SET_RST;
            S_SET_RST:    if (xfer) state_d = S_SET_DIS;
            S_SET_DIS:    if (xfer) state_d = S_CLR_PWDN;
            S_CLR_PWDN:   if (xfer) state_d = S_CLR_DIS;
            S_CLR_DIS:    if (xfer) state_d = S_WR_MULT;
            S_WR_MULT, S_WR_DIV: begin
                if (xfer) begin
                    if (pick_found)    state_d = S_WR_DIV;
                    else if (go_armed) state_d = S_GO_CMD;
                    else               state_d = S_CLR_RST;
                end
            end
            S_GO_CMD:     if (xfer) state_d = S_POLL_STAT;
            S_POLL_STAT:  if (xfer && !bus_rdata[0]) state_d = S_CLR_RST;
            S_CLR_RST:    if (xfer) state_d = S_WAIT_LOCK;
            S_WAIT_LOCK:  if (tmr_zero) state_d = S_SET_PLLEN;
            S_SET_PLLEN:  if (xfer) state_d = S_DONE;
            S_DONE:       state_d = S_IDLE;
            default:      state_d = S_IDLE;
        endcase
    end

    // state register and datapath
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= S_IDLE;
            shadow_q <= '0;
            base_q   <= '0;
            mult_q   <= '0;
            vld_q    <= '0;
            slot_q   <= '0;
            for (int i = 0; i < NUM_SLOT; i++) ratio_q[i] <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == S_IDLE && start) begin
                base_q     <= base_addr;
                mult_q     <= cfg_mult;
                ratio_q[0] <= cfg_prediv;
                ratio_q[1] <= cfg_postdiv;
                vld_q[0]   <= cfg_prediv_vld;
                vld_q[1]   <= cfg_postdiv_vld;
                for (int k = 0; k < NUM_ODIV; k++) begin
                    ratio_q[k+2] <= cfg_odiv[k*DIV_W +: DIV_W];
                    vld_q[k+2]   <= cfg_odiv_vld[k];
                end
            end
            if (xfer && state_q == S_RD_CTRL) shadow_q <= bus_rdata;
            if (xfer && bus_we && bus_addr == base_q + ADDR_W'(OFS_CTRL)) shadow_q <= bus_wdata;
            if (xfer && (state_q == S_WR_MULT || state_q == S_WR_DIV) && pick_found)
                slot_q <= pick_idx;
        end
    end

    // outputs
    always_comb begin
        bus_req   = 1'b0;
        bus_we    = 1'b0;
        bus_addr  = base_q + ADDR_W'(OFS_CTRL);
        bus_wdata = shadow_q;
        unique case (state_q)
            S_RD_CTRL: bus_req = 1'b1;
            S_CLR_CKMODE: begin
                bus_req = 1'b1; bus_we = 1'b1;
                bus_wdata = shadow_q & ~(32'h1 << B_CKMODE);
            end
            S_CLR_ENSRC: begin
                bus_req = 1'b1; bus_we = 1'b1;
                bus_wdata = shadow_q & ~(32'h1 << B_ENSRC);
            end
            S_CLR_PLLEN: begin
                bus_req = 1'b1; bus_we = 1'b1;
                bus_wdata = shadow_q & ~(32'h1 << B_PLLEN);
            end
            S_SET_RST: begin
                bus_req = 1'b1; bus_we = 1'b1;
                bus_wdata = shadow_q | (32'h1 << B_RST);
            end
            S_SET_DIS: begin
                bus_req = 1'b1; bus_we = 1'b1;
                bus_wdata = shadow_q | (32'h1 << B_DIS);
            end
            S_CLR_PWDN: begin
                bus_req = 1'b1; bus_we = 1'b1;
                bus_wdata = shadow_q & ~(32'h1 << B_PWRDN);
            end
            S_CLR_DIS: begin
                bus_req = 1'b1; bus_we = 1'b1;
                bus_wdata = shadow_q & ~(32'h1 << B_DIS);
            end
            S_WR_MULT: begin
                bus_req = 1'b1; bus_we = 1'b1;
                bus_addr  = base_q + ADDR_W'(OFS_MULT);
                bus_wdata = {24'h0, mult_m1[7:0]};
            end
            S_WR_DIV: begin
                bus_req = 1'b1; bus_we = 1'b1;
                bus_addr  = base_q + ADDR_W'(slot_offset(int'(slot_q)));
                bus_wdata = 32'h8000 | 32'(ratio_m1);
            end
            S_GO_CMD: begin
                bus_req = 1'b1; bus_we = 1'b1;
                bus_addr  = base_q + ADDR_W'(OFS_CMD);
                bus_wdata = 32'h1;
            end
            S_POLL_STAT: begin
                bus_req  = 1'b1;
                bus_addr = base_q + ADDR_W'(OFS_STAT);
            end
            S_CLR_RST: begin
                bus_req = 1'b1; bus_we = 1'b1;
                bus_wdata = shadow_q & ~(32'h1 << B_RST);
            end
            S_SET_PLLEN: begin
                bus_req = 1'b1; bus_we = 1'b1;
                bus_wdata = shadow_q | (32'h1 << B_PLLEN);
            end
            default: ;
        endcase
    end

    assign busy = (state_q != S_IDLE);
    assign done = (state_q == S_DONE);

    // R11
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req && !bus_ack |=> bus_req && $stable(bus_we) && $stable(bus_addr) && $stable(bus_wdata));

    // R9
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done && !busy);

    // R10
    busy_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(start));

    // R7
    go_needs_odiv_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req && bus_we && (bus_addr == base_q + ADDR_W'(OFS_CMD)) |-> go_armed);

endmodule

// File: tb/pll_bringup_seq_tb.sv
module pll_bringup_seq_tb;

    localparam int ADDR_W = 32;
    localparam int MULT_W = 9;
    localparam int DIV_W  = 5;
    localparam int BYP    = 4;
    localparam int LOCK   = 300;

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic                 start = 1'b0;
    logic [ADDR_W-1:0]    base_addr = 32'h4000_0000;
    logic [MULT_W-1:0]    cfg_mult = '0;
    logic [DIV_W-1:0]     cfg_prediv = '0, cfg_postdiv = '0;
    logic                 cfg_prediv_vld = 1'b0, cfg_postdiv_vld = 1'b0;
    logic [5*DIV_W-1:0]   cfg_odiv = '0;
    logic [4:0]           cfg_odiv_vld = '0;
    logic                 bus_req, bus_we, busy, done;
    logic [ADDR_W-1:0]    bus_addr;
    logic [31:0]          bus_wdata;
    logic [31:0]          bus_rdata = '0;
    logic                 bus_ack = 1'b0;

    always #4 clk = ~clk;

    pll_bringup_seq #(.ADDR_W(ADDR_W), .MULT_W(MULT_W), .DIV_W(DIV_W),
                      .BYP_CYC(BYP), .LOCK_CYC(LOCK)) u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .base_addr(base_addr),
        .cfg_mult(cfg_mult), .cfg_prediv(cfg_prediv), .cfg_prediv_vld(cfg_prediv_vld),
        .cfg_postdiv(cfg_postdiv), .cfg_postdiv_vld(cfg_postdiv_vld),
        .cfg_odiv(cfg_odiv), .cfg_odiv_vld(cfg_odiv_vld),
        .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .bus_ack(bus_ack), .busy(busy), .done(done)
    );

    // slave model settings (written by the scenario task between runs)
    logic [31:0] init_ctrl = '0;
    int          lat = 0;
    int          poll_n = 0;

    // bus slave model
    int dly = 0;
    int go_left = 0;
    always @(posedge clk) begin
        if (bus_req && bus_ack) begin
            bus_ack <= 1'b0;
            if (bus_we && bus_addr == base_addr + 32'h138) go_left <= poll_n;
            if (!bus_we && bus_addr == base_addr + 32'h13C && go_left != 0) go_left <= go_left - 1;
        end else if (bus_req) begin
            if (dly >= lat) begin
                dly     <= 0;
                bus_ack <= 1'b1;
                if (bus_addr == base_addr + 32'h100)      bus_rdata <= init_ctrl;
                else if (bus_addr == base_addr + 32'h13C) bus_rdata <= (go_left != 0) ? 32'h1 : 32'h0;
                else                                      bus_rdata <= 32'hDEAD_BEEF;
            end else begin
                dly <= dly + 1;
            end
        end
    end

    // expected transaction stream
    bit          q_we[$];
    logic [31:0] q_addr[$];
    logic [31:0] q_data[$];
    int          q_gap[$];
    string       q_tag[$];

    int n_chk = 0;
    int n_bad = 0;

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic push(input bit we, input logic [31:0] ofs, input logic [31:0] data,
                        input int gap, input string tag);
        q_we.push_back(we);
        q_addr.push_back(base_addr + ofs);
        q_data.push_back(data);
        q_gap.push_back(gap);
        q_tag.push_back(tag);
    endtask

    task automatic build_expected();
        logic [31:0] v;
        logic [31:0] divofs [7];
        bit          vld [7];
        logic [DIV_W-1:0] rat [7];
        divofs = '{32'h114, 32'h128, 32'h118, 32'h11C, 32'h120, 32'h160, 32'h164};
        vld[0] = cfg_prediv_vld;  rat[0] = cfg_prediv;
        vld[1] = cfg_postdiv_vld; rat[1] = cfg_postdiv;
        for (int k = 0; k < 5; k++) begin
            vld[k+2] = cfg_odiv_vld[k];
            rat[k+2] = cfg_odiv[k*DIV_W +: DIV_W];
        end
        v = init_ctrl;
        push(1'b0, 32'h100, 32'h0, 0, "R1");
        v = v & ~32'h100; push(1'b1, 32'h100, v, 0, "R2");
        v = v & ~32'h020; push(1'b1, 32'h100, v, 0, "R2");
        v = v & ~32'h001; push(1'b1, 32'h100, v, 0, "R2");
        v = v |  32'h008; push(1'b1, 32'h100, v, BYP + 1, "R3");
        v = v |  32'h010; push(1'b1, 32'h100, v, 0, "R4");
        v = v & ~32'h002; push(1'b1, 32'h100, v, 0, "R4");
        v = v & ~32'h010; push(1'b1, 32'h100, v, 0, "R4");
        push(1'b1, 32'h110, (32'(cfg_mult) - 1) & 32'hFF, 0, "R5");
        for (int s = 0; s < 7; s++)
            if (vld[s]) push(1'b1, divofs[s], 32'h8000 | (32'(rat[s]) - 1), 0, "R6");
        if (cfg_odiv_vld != 0) begin
            push(1'b1, 32'h138, 32'h1, 0, "R7");
            for (int p = 0; p <= poll_n; p++) push(1'b0, 32'h13C, 32'h0, 0, "R7");
        end
        v = v & ~32'h008; push(1'b1, 32'h100, v, 0, "R8");
        v = v |  32'h001; push(1'b1, 32'h100, v, LOCK + 1, "R8");
    endtask

    // per-clock reference comparison
    logic        start_seen = 1'b0;
    bit          exp_busy = 1'b0;
    bit          done_exp = 1'b0;
    bit          run_fin = 1'b0;
    int          run_dones = 0;
    int          cyc = 0;
    int          tr_start = 0;
    int          last_ack = 0;
    bit          pend_prev = 1'b0;
    logic [31:0] prev_addr = '0, prev_wdata = '0;
    logic        prev_we = 1'b0;

    task automatic summary();
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    endtask

    always @(posedge clk) start_seen <= start;

    always @(negedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            chk(1'b0, "WDOG", "watchdog expired", 32'(cyc), 32'd150000);
            summary();
            $finish;
        end
        if (!rst_n) begin
            chk(!bus_req && !busy && !done, "R1", "reset outputs",
                {29'h0, bus_req, busy, done}, 32'h0);
        end else begin
            if (start_seen && !exp_busy) exp_busy = 1'b1;
            chk(busy === exp_busy, "R9", "busy", 32'(busy), 32'(exp_busy));
            chk(done === done_exp, "R9", "done", 32'(done), 32'(done_exp));
            done_exp = 1'b0;
            if (done) begin
                exp_busy = 1'b0;
                run_fin  = 1'b1;
                run_dones++;
                chk(q_addr.size() == 0, "R9", "done before sequence end",
                    32'(q_addr.size()), 32'h0);
            end
            if (pend_prev)
                chk(bus_req && bus_we == prev_we && bus_addr == prev_addr && bus_wdata == prev_wdata,
                    "R11", "request changed before ack", bus_addr, prev_addr);
            if (bus_req && !pend_prev) tr_start = cyc;
            if (bus_req && bus_ack) begin
                if (q_addr.size() == 0) begin
                    chk(1'b0, "R10", "unexpected transfer", bus_addr, 32'h0);
                end else begin
                    string tg;
                    tg = q_tag.pop_front();
                    begin
                        bit e_we; logic [31:0] e_a, e_d; int e_g;
                        e_we = q_we.pop_front(); e_a = q_addr.pop_front();
                        e_d = q_data.pop_front(); e_g = q_gap.pop_front();
                        chk(bus_we == e_we, tg, "direction", 32'(bus_we), 32'(e_we));
                        chk(bus_addr == e_a, tg, "address", bus_addr, e_a);
                        if (e_we) chk(bus_wdata == e_d, tg, "write data", bus_wdata, e_d);
                        if (e_g > 0) chk(tr_start - last_ack >= e_g, tg, "wait length",
                                         32'(tr_start - last_ack), 32'(e_g));
                    end
                    if (q_addr.size() == 0) done_exp = 1'b1;
                end
                last_ack = cyc;
            end
            pend_prev  = bus_req && !bus_ack;
            prev_we    = bus_we;
            prev_addr  = bus_addr;
            prev_wdata = bus_wdata;
        end
    end

    task automatic run(input logic [31:0] ini, input int m, input int pre, input bit pre_v,
                       input int post, input bit post_v, input logic [5*DIV_W-1:0] od,
                       input logic [4:0] od_v, input int l, input int pn, input bit mid);
        init_ctrl = ini; lat = l; poll_n = pn;
        cfg_mult = MULT_W'(m);
        cfg_prediv = DIV_W'(pre); cfg_prediv_vld = pre_v;
        cfg_postdiv = DIV_W'(post); cfg_postdiv_vld = post_v;
        cfg_odiv = od; cfg_odiv_vld = od_v;
        build_expected();
        run_fin = 1'b0; run_dones = 0;
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        if (mid) begin
            // R10: start and new configuration while busy must be ignored
            repeat (12) @(negedge clk);
            cfg_mult = 9'd77; cfg_prediv_vld = ~pre_v; cfg_odiv_vld = ~od_v;
            start = 1'b1;
            @(negedge clk); start = 1'b0;
        end
        while (!run_fin) @(posedge clk);
        repeat (4) @(posedge clk);
        chk(run_dones == 1, "R10", "done count per run", 32'(run_dones), 32'h1);
        chk(q_addr.size() == 0, "R10", "leftover expected transfers", 32'(q_addr.size()), 32'h0);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        // all dividers configured, zero-latency acks
        run(32'h0000_0133, 20, 2, 1, 3, 1, {5'd5, 5'd4, 5'd3, 5'd2, 5'd1}, 5'b11111, 0, 2, 0);
        // no dividers: no GO; multiplier 256 wraps to 0xFF
        run(32'hFFFF_FFFF, 256, 0, 0, 0, 0, '0, 5'b00000, 1, 3, 0);
        // pre-divider plus output dividers 3 and 5, multiplier 1
        run(32'h0000_0123, 1, 7, 1, 0, 0, {5'd31, 5'd0, 5'd9, 5'd0, 5'd0}, 5'b10100, 2, 0, 0);
        // post-divider only: no GO; start and config changes while busy
        run(32'h0000_0FFF, 50, 0, 0, 4, 1, {5'd6, 5'd6, 5'd6, 5'd6, 5'd6}, 5'b00000, 0, 1, 1);
        // every divider, long busy poll, slow acks, restart attempt mid-run
        run(32'h1234_5678, 100, 1, 1, 16, 1, {5'd2, 5'd8, 5'd1, 5'd12, 5'd30}, 5'b11111, 3, 4, 1);
        summary();
        $finish;
    end

endmodule